// File: doc/BRIEF.md
# Priority Vectored Interrupt Controller

This block collects interrupt requests from up to a few hundred peripheral sources plus a handful of external pins and reduces them to one request line and one vector number for the processor. Each source owns a pending flag, an enable bit, a five-bit priority (a three-bit major level above a two-bit sub-level) and a free 32-bit offset word that software uses to locate its handler. A registered arbiter chooses among pending, enabled sources and drives the request and the winning index.

Software reaches every register through a simple 32-bit register bus. Each control, flag, enable and priority word has three alias addresses that clear, set or invert only the bits written as one. Sources come in three kinds chosen by parameter. Edge sources latch on a request rising edge. Persistent sources cannot be cleared while their request is still high. Pin sources latch on the one pin edge that the control register selects.

Top module: `prio_vic`

## Requirements
- R1: After reset every flag, enable, priority, polarity bit and offset word reads zero, `cpu_irq` is 0 and `cpu_vec` is 0.
- R2: Flags start at 0x040 and enables at 0x0C0. Each bank uses one word per 32 sources, with words 0x10 apart. Source n is bit n%32 of word n/32.
- R3: Priorities start at 0x140, with words 0x10 apart. Source n uses bits (n%4)*8+4 .. (n%4)*8 of word n/4. Within that field, bits 4:2 are the major level and bits 1:0 the sub-level. Lane bits 7:5 read 0.
- R4: Address offset +0x0 of a control, flag, enable or priority word writes it plainly. Offset +0x4 clears the bits written as one, +0x8 sets them and +0xC inverts them. Bits written as zero keep their value.
- R5: An edge source sets its flag on a rising edge of its request. A flag cleared by software stays clear while the request is still held high.
- R6: A persistent source (bits 15:8 by default) keeps its flag set while its request is high, even after a clear. Once the request is low, a clear takes effect.
- R7: External pin i drives source EXT_BASE+i (sources 0..3 by default), and the matching `src_req` bit is ignored. Control bit i (address 0x000) chooses the edge: 1 for rising, 0 for falling. Only the chosen edge sets the flag.
- R8: The winner is the pending, enabled source with the highest major level, then the highest sub-level, then the lowest index.
- R9: A source with major level 0, or one that is disabled or not pending, never raises `cpu_irq`. With no candidate, `cpu_irq` is 0 and `cpu_vec` is 0.
- R10: A request sampled at clock edge t sets the flag at t. `cpu_irq` and `cpu_vec` reflect it at edge t+1.
- R11: Bits 7:0 of the status word at 0x020 equal `cpu_vec`. The offset word of source n is a plain read/write word at 0x540+4*n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 12 | Register byte address |
| bus_wr | input | 1 | Write strobe for the current address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the current address (combinational) |
| src_req | input | 64 | Peripheral request lines |
| ext_pin | input | 4 | External interrupt pins |
| cpu_irq | output | 1 | Interrupt request to the processor |
| cpu_vec | output | 8 | Index of the winning source |

## Verification
Directed cases cover the following:
- Major levels that tie, where the sub-level must decide.
- Full ties, where the lowest index must win.
- A higher major level beating a higher sub-level.
- A lone candidate with major level 0, which separates priority gating from enable and pending gating.
- A request held across a software clear, which separates edge sources from persistent ones.
- A pin toggled under both polarity settings, with a stray `src_req` pulse on the same source.

A seeded random phase then mixes every alias operation on enables, flags and priority lanes with edge pulses. After each step it compares the request and vector with a reference arbiter in the bench, which exposes faults in the bit and lane mapping and in the tie-break order.

// File: rtl/vic_pkg.sv
package vic_pkg;

   typedef enum logic [1:0] {
      OP_WRITE = 2'd0,
      OP_CLEAR = 2'd1,
      OP_SET   = 2'd2,
      OP_FLIP  = 2'd3
   } bus_op_e;

   typedef enum logic [2:0] {
      RG_NONE,
      RG_CTRL,
      RG_STAT,
      RG_FLAG,
      RG_EN,
      RG_PRIO,
      RG_OFF
   } region_e;

   typedef enum logic [1:0] {
      K_EDGE,
      K_LEVEL,
      K_PULSE
   } src_kind_e;

   localparam int CTRL_BASE = 'h000;
   localparam int STAT_BASE = 'h020;
   localparam int FLAG_BASE = 'h040;
   localparam int EN_BASE   = 'h0C0;
   localparam int PRIO_BASE = 'h140;
   localparam int OFF_BASE  = 'h540;
   localparam int BANK_STEP = 'h10;

   function automatic logic [31:0] apply_op(logic [31:0] cur, logic [31:0] wd, bus_op_e op);
      case (op)
         OP_WRITE: return wd;
         OP_CLEAR: return cur & ~wd;
         OP_SET:   return cur | wd;
         default:  return cur ^ wd;
      endcase
   endfunction

endpackage

// File: rtl/vic_pin_edge.sv
module vic_pin_edge #(
   parameter int N = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] pin,
   input  logic [N-1:0] rise_sel,
   output logic [N-1:0] evt
);

   logic [N-1:0] pin_q;

   always_ff @(posedge clk) begin
      if (!rst_n) pin_q <= '0;
      else        pin_q <= pin;
   end

   for (genvar i = 0; i < N; i++) begin : g_pin
      assign evt[i] = rise_sel[i] ? (pin[i] & ~pin_q[i]) : (~pin[i] & pin_q[i]);

      // R7: with the polarity unchanged, one edge never yields two events in a row
      a_r7_single_event: assert property (@(posedge clk) disable iff (!rst_n)
         (evt[i] ##1 (rise_sel[i] == $past(rise_sel[i]))) |-> !evt[i]);
   end

endmodule

// File: rtl/vic_flag_cell.sv
module vic_flag_cell import vic_pkg::*; #(
   parameter src_kind_e KIND = K_EDGE
) (
   input  logic clk,
   input  logic rst_n,
   input  logic req,
   input  logic sw_wr,
   input  logic sw_val,
   output logic flag
);

   logic hw_set;

   if (KIND == K_EDGE) begin : g_edge
      logic req_q;
      always_ff @(posedge clk) begin
         if (!rst_n) req_q <= 1'b0;
         else        req_q <= req;
      end
      assign hw_set = req & ~req_q;

      // R5: a held request produces a single set event
      a_r5_one_shot: assert property (@(posedge clk) disable iff (!rst_n)
         hw_set |=> !hw_set);
   end else begin : g_direct
      assign hw_set = req;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)      flag <= 1'b0;
      else if (hw_set) flag <= 1'b1;
      else if (sw_wr)  flag <= sw_val;
   end

   if (KIND == K_LEVEL) begin : g_level_chk
      // R6: persistent flag cannot drop while its request is present
      a_r6_level_sticky: assert property (@(posedge clk) disable iff (!rst_n)
         req |=> flag);
   end

   // R5: a software clear with no competing set always lands
   a_r5_sw_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (sw_wr && !sw_val && !hw_set) |=> !flag);

endmodule

// File: rtl/vic_arbiter.sv
module vic_arbiter #(
   parameter int N     = 64,
   parameter int PW    = 5,
   parameter int SUB_W = 2,
   parameter int IW    = 6
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [N-1:0]          flag,
   input  logic [N-1:0]          en,
   input  logic [N-1:0][PW-1:0]  prio,
   output logic                  irq,
   output logic [IW-1:0]         vec
);

   localparam int MAJ_W = PW - SUB_W;

   if (MAJ_W < 1) begin : g_bad_w
      $error("priority field needs at least one major bit");
   end

   logic [N-1:0]  elig;
   logic          any_c;
   logic [PW-1:0] best_c;
   logic [IW-1:0] idx_c;

   for (genvar n = 0; n < N; n++) begin : g_elig
      assign elig[n] = flag[n] & en[n] & (prio[n][PW-1:SUB_W] != '0);
   end

   // downward scan with >= leaves the lowest index on a full tie
   always_comb begin
      any_c  = 1'b0;
      best_c = '0;
      idx_c  = '0;
      for (int n = N - 1; n >= 0; n--) begin
         if (elig[n] && (!any_c || prio[n] >= best_c)) begin
            any_c  = 1'b1;
            best_c = prio[n];
            idx_c  = IW'(n);
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         irq <= 1'b0;
         vec <= '0;
      end else begin
         irq <= any_c;
         vec <= idx_c;
      end
   end

   // R9: no candidate in a cycle means no request in the next one
   a_r9_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !(|elig) |=> (!irq && vec == '0));

   // R10: any candidate is reported one cycle later
   a_r10_latency: assert property (@(posedge clk) disable iff (!rst_n)
      (|elig) |=> irq);

endmodule

// File: rtl/prio_vic.sv
module prio_vic import vic_pkg::*; #(
   parameter int                  NUM_SRC      = 64,
   parameter int                  NUM_EXT      = 4,
   parameter int                  EXT_BASE     = 0,
   parameter int                  ADDR_W       = 12,
   parameter logic [NUM_SRC-1:0]  PERSIST_MASK = 64'h0000_0000_0000_FF00
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [ADDR_W-1:0]  bus_addr,
   input  logic               bus_wr,
   input  logic [31:0]        bus_wdata,
   output logic [31:0]        bus_rdata,
   input  logic [NUM_SRC-1:0] src_req,
   input  logic [NUM_EXT-1:0] ext_pin,
   output logic               cpu_irq,
   output logic [7:0]         cpu_vec
);

   localparam int NW     = NUM_SRC / 32;
   localparam int NPW    = NUM_SRC / 4;
   localparam int IDX_W  = $clog2(NUM_SRC);
   localparam int PRIO_W = 5;
   localparam int SUB_W  = 2;
   localparam int LANE_W = 8;

   if (NUM_SRC % 32 != 0 || NUM_SRC < 32 || NUM_SRC > 256) begin : g_bad_src
      $error("NUM_SRC must be a multiple of 32 in 32..256");
   end
   if (NUM_EXT < 1 || NUM_EXT > 32 || EXT_BASE < 0 || EXT_BASE + NUM_EXT > NUM_SRC) begin : g_bad_ext
      $error("external pins must map inside the source range");
   end
   if (PERSIST_MASK[EXT_BASE +: NUM_EXT] != '0) begin : g_bad_mask
      $error("pin sources cannot be persistent");
   end
   if (ADDR_W > 32 || OFF_BASE + 4 * NUM_SRC > (1 << ADDR_W)) begin : g_bad_addr
      $error("ADDR_W does not cover the offset words");
   end

   // ---------------- address decode ----------------
   region_e     region;
   logic [31:0] a32;
   logic [31:0] widx;
   bus_op_e     op;

   always_comb begin
      a32    = 32'(bus_addr);
      op     = bus_op_e'(bus_addr[3:2]);
      region = RG_NONE;
      widx   = '0;
      if (a32 < 32'(CTRL_BASE + BANK_STEP)) begin
         region = RG_CTRL;
      end else if (a32 >= 32'(STAT_BASE) && a32 < 32'(STAT_BASE + BANK_STEP)) begin
         region = RG_STAT;
      end else if (a32 >= 32'(FLAG_BASE) && a32 < 32'(FLAG_BASE + BANK_STEP * NW)) begin
         region = RG_FLAG;
         widx   = (a32 - 32'(FLAG_BASE)) >> 4;
      end else if (a32 >= 32'(EN_BASE) && a32 < 32'(EN_BASE + BANK_STEP * NW)) begin
         region = RG_EN;
         widx   = (a32 - 32'(EN_BASE)) >> 4;
      end else if (a32 >= 32'(PRIO_BASE) && a32 < 32'(PRIO_BASE + BANK_STEP * NPW)) begin
         region = RG_PRIO;
         widx   = (a32 - 32'(PRIO_BASE)) >> 4;
      end else if (a32 >= 32'(OFF_BASE) && a32 < 32'(OFF_BASE + 4 * NUM_SRC) && a32[1:0] == 2'b00) begin
         region = RG_OFF;
         widx   = (a32 - 32'(OFF_BASE)) >> 2;
      end
   end

   // ---------------- register state ----------------
   logic [NUM_EXT-1:0]             pol_q;
   logic [NUM_SRC-1:0]             flag_q, flag_nxt;
   logic [NUM_SRC-1:0]             en_q, en_nxt;
   logic [NUM_SRC-1:0][PRIO_W-1:0] prio_q, prio_nxt;
   logic [31:0]                    ctrl_nxt;
   logic [31:0]                    lane_t;
   logic [31:0]                    off_q [NUM_SRC];
   logic [IDX_W-1:0]               win_idx;

   always_comb begin
      ctrl_nxt = apply_op(32'(pol_q), bus_wdata, op);
      lane_t   = '0;
      for (int w = 0; w < NW; w++) begin
         en_nxt[w*32 +: 32]   = apply_op(en_q[w*32 +: 32], bus_wdata, op);
         flag_nxt[w*32 +: 32] = apply_op(flag_q[w*32 +: 32], bus_wdata, op);
      end
      for (int n = 0; n < NUM_SRC; n++) begin
         lane_t      = apply_op(32'(prio_q[n]), 32'(bus_wdata[(n%4)*LANE_W +: PRIO_W]), op);
         prio_nxt[n] = lane_t[PRIO_W-1:0];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pol_q  <= '0;
         en_q   <= '0;
         prio_q <= '0;
      end else if (bus_wr) begin
         if (region == RG_CTRL) pol_q <= ctrl_nxt[NUM_EXT-1:0];
         for (int w = 0; w < NW; w++) begin
            if (region == RG_EN && widx == 32'(w)) en_q[w*32 +: 32] <= en_nxt[w*32 +: 32];
         end
         for (int n = 0; n < NUM_SRC; n++) begin
            if (region == RG_PRIO && widx == 32'(n / 4)) prio_q[n] <= prio_nxt[n];
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int n = 0; n < NUM_SRC; n++) off_q[n] <= '0;
      end else if (bus_wr && region == RG_OFF) begin
         for (int n = 0; n < NUM_SRC; n++) begin
            if (widx == 32'(n)) off_q[n] <= bus_wdata;
         end
      end
   end

   // ---------------- sources ----------------
   logic [NUM_EXT-1:0] pin_evt;

   vic_pin_edge #(.N(NUM_EXT)) u_pins (
      .clk      (clk),
      .rst_n    (rst_n),
      .pin      (ext_pin),
      .rise_sel (pol_q),
      .evt      (pin_evt)
   );

   for (genvar n = 0; n < NUM_SRC; n++) begin : g_src
      logic sw_wr;
      assign sw_wr = bus_wr && (region == RG_FLAG) && (widx == 32'(n / 32));

      if (n >= EXT_BASE && n < EXT_BASE + NUM_EXT) begin : g_ext
         vic_flag_cell #(.KIND(K_PULSE)) u_cell (
            .clk(clk), .rst_n(rst_n), .req(pin_evt[n - EXT_BASE]),
            .sw_wr(sw_wr), .sw_val(flag_nxt[n]), .flag(flag_q[n]));
      end else if (PERSIST_MASK[n]) begin : g_lvl
         vic_flag_cell #(.KIND(K_LEVEL)) u_cell (
            .clk(clk), .rst_n(rst_n), .req(src_req[n]),
            .sw_wr(sw_wr), .sw_val(flag_nxt[n]), .flag(flag_q[n]));
      end else begin : g_edg
         vic_flag_cell #(.KIND(K_EDGE)) u_cell (
            .clk(clk), .rst_n(rst_n), .req(src_req[n]),
            .sw_wr(sw_wr), .sw_val(flag_nxt[n]), .flag(flag_q[n]));
      end
   end

   // ---------------- arbitration ----------------
   vic_arbiter #(.N(NUM_SRC), .PW(PRIO_W), .SUB_W(SUB_W), .IW(IDX_W)) u_arb (
      .clk   (clk),
      .rst_n (rst_n),
      .flag  (flag_q),
      .en    (en_q),
      .prio  (prio_q),
      .irq   (cpu_irq),
      .vec   (win_idx)
   );

   assign cpu_vec = 8'(win_idx);

   // ---------------- read mux ----------------
   always_comb begin
      bus_rdata = '0;
      case (region)
         RG_CTRL: bus_rdata = 32'(pol_q);
         RG_STAT: bus_rdata = {24'b0, cpu_vec};
         RG_FLAG: for (int w = 0; w < NW; w++) if (widx == 32'(w)) bus_rdata = flag_q[w*32 +: 32];
         RG_EN:   for (int w = 0; w < NW; w++) if (widx == 32'(w)) bus_rdata = en_q[w*32 +: 32];
         RG_PRIO: for (int k = 0; k < NPW; k++) begin
            if (widx == 32'(k)) begin
               for (int l = 0; l < 4; l++) bus_rdata[l*LANE_W +: LANE_W] = LANE_W'(prio_q[k*4 + l]);
            end
         end
         RG_OFF:  for (int n = 0; n < NUM_SRC; n++) if (widx == 32'(n)) bus_rdata = off_q[n];
         default: bus_rdata = '0;
      endcase
   end

   // R11: status reflects the registered winner at all times
   a_r11_status_vec: assert property (@(posedge clk) disable iff (!rst_n)
      (region == RG_STAT) |-> (bus_rdata[7:0] == cpu_vec));

endmodule

// File: tb/prio_vic_tb_top.sv
module prio_vic_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [11:0] bus_addr = '0;
   logic        bus_wr = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [63:0] src_req = '0;
   logic [3:0]  ext_pin = '0;
   logic        cpu_irq;
   logic [7:0]  cpu_vec;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   bit       m_flag [64];
   bit       m_en   [64];
   bit [4:0] m_prio [64];

   always #4 clk = ~clk;

   prio_vic dut_i (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .src_req(src_req),
      .ext_pin(ext_pin), .cpu_irq(cpu_irq), .cpu_vec(cpu_vec)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] bop(logic [31:0] cur, logic [31:0] d, int op);
      case (op)
         0: return d;
         1: return cur & ~d;
         2: return cur | d;
         default: return cur ^ d;
      endcase
   endfunction

   task automatic step(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic wr(input int addr, input logic [31:0] d);
      @(negedge clk);
      bus_addr = 12'(addr); bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input int addr, output logic [31:0] d);
      bus_addr = 12'(addr);
      #1;
      d = bus_rdata;
   endtask

   task automatic pulse(input int n);
      @(negedge clk); src_req[n] = 1'b1;
      @(negedge clk); src_req[n] = 1'b0;
   endtask

   task automatic mwr(input int kind, input int word, input int op, input logic [31:0] d);
      logic [31:0] cur, nw;
      int base;
      base = (kind == 0) ? 'h40 : (kind == 1) ? 'hC0 : 'h140;
      cur = '0;
      if (kind == 2) for (int l = 0; l < 4; l++) cur[l*8 +: 5] = m_prio[word*4 + l];
      else for (int b = 0; b < 32; b++) cur[b] = (kind == 0) ? m_flag[word*32 + b] : m_en[word*32 + b];
      nw = bop(cur, d, op);
      if (kind == 2) for (int l = 0; l < 4; l++) m_prio[word*4 + l] = nw[l*8 +: 5];
      else for (int b = 0; b < 32; b++) begin
         if (kind == 0) m_flag[word*32 + b] = nw[b];
         else           m_en[word*32 + b] = nw[b];
      end
      wr(base + 16*word + 4*op, d);
   endtask

   task automatic exp_win(output bit irq, output int vec);
      bit [4:0] best;
      irq = 0; vec = 0; best = 0;
      for (int n = 63; n >= 0; n--) begin
         if (m_flag[n] && m_en[n] && m_prio[n][4:2] != 0 && (!irq || m_prio[n] >= best)) begin
            irq = 1; best = m_prio[n]; vec = n;
         end
      end
   endtask

   task automatic check_out(input string tag);
      bit ei; int ev;
      exp_win(ei, ev);
      check({tag, " irq"}, 32'(cpu_irq), 32'(ei));
      check({tag, " vec"}, 32'(cpu_vec), 32'(ev));
   endtask

   task automatic do_reset();
      @(negedge clk); rst_n = 1'b0;
      src_req = '0; ext_pin = '0; bus_wr = 1'b0;
      step(3);
      rst_n = 1'b1;
      for (int n = 0; n < 64; n++) begin m_flag[n] = 0; m_en[n] = 0; m_prio[n] = 0; end
   endtask

   task automatic finish_run();
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   endtask

   initial begin
      #(8 * 150000);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog actual=timeout expected=completion");
         finish_run();
      end
   end

   initial begin
      logic [31:0] d;
      void'($urandom(32'd20240611));
      step(2);
      do_reset();
      step(1);

      // R1 reset state
      check("R1 irq", 32'(cpu_irq), 0);
      check("R1 vec", 32'(cpu_vec), 0);
      rd('h040, d); check("R1 flags", d, 0);
      rd('h0C0, d); check("R1 enables", d, 0);
      rd('h140, d); check("R1 prio", d, 0);
      rd('h000, d); check("R1 ctrl", d, 0);
      rd('h540, d); check("R1 offset", d, 0);
      rd('h020, d); check("R1 status", d, 0);

      // R2 bit/word mapping for source 37
      pulse(37);
      rd('h050, d); check("R2 word1", d, 32'h20);
      rd('h040, d); check("R2 word0", d, 0);
      wr('h054, 32'h20);
      rd('h050, d); check("R2 clear", d, 0);

      // R4 alias operations on enable word 0
      wr('h0C0, 32'h0000F0F0);
      wr('h0C8, 32'h0000000F); rd('h0C0, d); check("R4 set", d, 32'h0000F0FF);
      wr('h0C4, 32'h000000F0); rd('h0C0, d); check("R4 clear", d, 32'h0000F00F);
      wr('h0CC, 32'hFFFF0000); rd('h0C0, d); check("R4 invert", d, 32'hFFFFF00F);
      wr('h0C0, 32'h0);

      // R3 lane packing, word 9 holds sources 36..39
      wr('h1D0, 32'hFFFFFFFF); rd('h1D0, d); check("R3 lanes", d, 32'h1F1F1F1F);
      wr('h1D4, 32'h00000C00); rd('h1D0, d); check("R3 lane clear", d, 32'h1F1F131F);
      wr('h1D0, 32'h0);

      // R10 latency with source 5 at major 3 sub 1
      wr('h150, 32'h00000D00);
      wr('h0C8, 32'h20);
      @(negedge clk); src_req[5] = 1'b1;
      @(negedge clk); src_req[5] = 1'b0;
      check("R10 not yet", 32'(cpu_irq), 0);
      @(negedge clk);
      check("R10 irq", 32'(cpu_irq), 1);
      check("R10 vec", 32'(cpu_vec), 5);
      rd('h020, d); check("R11 status", d, 5);

      // R8 ordering: 40 and 50 at (3,2) beat 5 at (3,1); tie goes to 40
      wr('h1E0, 32'h0000000E);
      wr('h200, 32'h000E0000);
      wr('h0D8, (32'h1 << 8) | (32'h1 << 18));
      pulse(50); pulse(40); step(1);
      check("R8 tie low index", 32'(cpu_vec), 40);
      wr('h054, 32'h1 << 8); step(1);
      check("R8 sub level", 32'(cpu_vec), 50);
      wr('h150, 32'h00001000); step(1);
      check("R8 major beats sub", 32'(cpu_vec), 5);

      // R9 gating
      wr('h0C0, 0); wr('h0D0, 0); step(1);
      check("R9 disabled", 32'(cpu_irq), 0);
      wr('h158, 32'h00030000);
      wr('h0C8, 32'h40);
      pulse(6); step(1);
      check("R9 major zero", 32'(cpu_irq), 0);
      check("R9 major zero vec", 32'(cpu_vec), 0);
      rd('h040, d); check("R9 flags pending", d, 32'h60);
      wr('h0C0, 0);

      // R5 edge source 20 cleared while held
      @(negedge clk); src_req[20] = 1'b1;
      step(2);
      rd('h040, d); check("R5 set", 32'(d[20]), 1);
      wr('h044, 32'h1 << 20);
      rd('h040, d); check("R5 clear while held", 32'(d[20]), 0);
      src_req[20] = 1'b0; step(2);
      rd('h040, d); check("R5 stays clear", 32'(d[20]), 0);

      // R6 persistent source 9
      @(negedge clk); src_req[9] = 1'b1;
      step(2);
      wr('h044, 32'h1 << 9);
      rd('h040, d); check("R6 clear ignored", 32'(d[9]), 1);
      src_req[9] = 1'b0; step(1);
      wr('h044, 32'h1 << 9);
      rd('h040, d); check("R6 clear after drop", 32'(d[9]), 0);

      // R7 pin 1 -> source 1
      @(negedge clk); ext_pin[1] = 1'b1; step(2);
      rd('h040, d); check("R7 rise ignored when falling", 32'(d[1]), 0);
      ext_pin[1] = 1'b0; step(2);
      rd('h040, d); check("R7 falling edge", 32'(d[1]), 1);
      wr('h044, 32'h2);
      wr('h008, 32'h2);
      rd('h000, d); check("R7 polarity set", d, 32'h2);
      pulse(1); step(1);
      rd('h040, d); check("R7 src_req ignored", 32'(d[1]), 0);
      @(negedge clk); ext_pin[1] = 1'b1; step(2);
      rd('h040, d); check("R7 rising edge", 32'(d[1]), 1);
      wr('h044, 32'h2);
      ext_pin[1] = 1'b0; step(2);
      rd('h040, d); check("R7 fall ignored when rising", 32'(d[1]), 0);

      // R11 offset words
      wr('h63C, 32'hDEADBEEF);
      rd('h63C, d); check("R11 offset 63", d, 32'hDEADBEEF);
      rd('h638, d); check("R11 offset 62", d, 0);

      // random phase against the bench model
      do_reset();
      step(1);
      check_out("R1 after reset");
      for (int it = 0; it < 400; it++) begin
         int sel;
         sel = int'($urandom % 4);
         case (sel)
            0: mwr(1, int'($urandom % 2), int'($urandom % 4), $urandom);
            1: mwr(2, int'($urandom % 16), int'($urandom % 4), $urandom);
            2: begin
               int n;
               n = 16 + int'($urandom % 48);
               pulse(n);
               m_flag[n] = 1;
            end
            default: mwr(0, int'($urandom % 2), int'($urandom % 4), $urandom & $urandom);
         endcase
         step(1);
         check_out("R8 random");
         if (it % 8 == 0) begin
            int w;
            logic [31:0] e;
            w = int'($urandom % 2);
            for (int b = 0; b < 32; b++) e[b] = m_en[w*32 + b];
            rd('h0C0 + 16*w, d); check("R4 random enable", d, e);
            for (int b = 0; b < 32; b++) e[b] = m_flag[w*32 + b];
            rd('h040 + 16*w, d); check("R2 random flags", d, e);
            rd('h020, d); check("R11 random status", d, 32'(cpu_vec));
         end
      end

      done = 1'b1;
      finish_run();
   end

endmodule